// File: doc/BRIEF.md
# Interval Capture Buffer with Zero-Fill Readout

This block sits between a decimating down-converter and a pulse compressor. It collects the complex (I/Q) samples of one pulse repetition interval in an internal FIFO. When enough samples for a whole interval are stored, it raises a ready flag. The compressor then asks for the interval with a read request.

On a granted request the block sends a trace of a fixed length, `TRACE_LEN` beats (1024 by default), with no gaps. The stored samples of the interval come first, in the order they were written. Zero-valued samples follow until the trace is full, so the compressor always sees the same number of range bins.

The number of samples that make up one interval is set on a run-time configuration input. An interval begins with a write that carries the start marker. Writes that would overflow the FIFO are dropped and recorded in a flag that stays set.

Top module: `pri_pad_buffer`

## Requirements
- R1: After reset `pri_ready`, `out_valid`, `out_last` and `overflow` are low, and `out_i`/`out_q` are zero.
- R2: A write with `wr_valid` and `wr_sop` both high starts an interval, and its sample is stored. Later writes without `wr_sop` are stored until the interval holds the effective length. Writes beyond that length, and writes before the first start marker, are discarded.
- R3: The effective length is `cfg_len`, limited to the range 1 to `TRACE_LEN`. A value of 0 acts as 1, and a value above `TRACE_LEN` acts as `TRACE_LEN`.
- R4: `pri_ready` is high exactly when no trace is in progress and the FIFO holds at least the effective length of samples.
- R5: If `rd_req` is high at a clock edge where `pri_ready` is high, `pri_ready` is low after that edge. The first output beat (`out_valid` high) appears after the following edge.
- R6: A trace is `TRACE_LEN` consecutive beats. First come the oldest stored samples, as many as the effective length sampled at the granted request, with `out_i` carrying the I part. Then come beats with `out_i` = `out_q` = 0. Both data outputs are zero whenever `out_valid` is low.
- R7: `out_last` is high on beat `TRACE_LEN` of a trace and on no other beat.
- R8: `pri_ready` stays low until `out_valid` has dropped after the last beat, even if a further interval is already stored.
- R9: A `rd_req` at an edge where `pri_ready` is low has no effect: no beat is produced from it.
- R10: A write that would be stored while the FIFO holds `DEPTH` samples is dropped and sets `overflow`. Only reset clears `overflow`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | LEN_W | Samples per interval (limited to 1..TRACE_LEN) |
| wr_valid | input | 1 | Write strobe for one I/Q sample |
| wr_sop | input | 1 | Marks the first sample of an interval |
| wr_i | input | DATA_W | In-phase sample |
| wr_q | input | DATA_W | Quadrature sample |
| pri_ready | output | 1 | A complete interval is stored and readout is idle |
| rd_req | input | 1 | Request from the compressor to stream one trace |
| out_valid | output | 1 | Output beat valid |
| out_last | output | 1 | Final beat of a trace |
| out_i | output | DATA_W | Output in-phase value |
| out_q | output | DATA_W | Output quadrature value |
| overflow | output | 1 | Sticky flag: a write was dropped on a full FIFO |

## Verification
The hardest state to reach is a full FIFO. It needs a full-length interval stored and left unread, and then a second interval that starts before any readout drains the first. The stimulus does this by setting `cfg_len` above the trace length, so the effective length is the maximum, and writing one interval plus a few more samples with no request. A second hard point is a stored interval that waits while a trace is still streaming. Two intervals are written with the request held high, which shows that the second grant comes only after the first trace has ended.

// File: rtl/pri_pad_buffer.sv
module pri_pad_buffer #(
  parameter int DATA_W    = 16,
  parameter int TRACE_LEN = 1024,
  parameter int DEPTH     = 1024,
  parameter int LEN_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              wr_valid,
  input  logic              wr_sop,
  input  logic [DATA_W-1:0] wr_i,
  input  logic [DATA_W-1:0] wr_q,
  output logic              pri_ready,
  input  logic              rd_req,
  output logic              out_valid,
  output logic              out_last,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q,
  output logic              overflow
);
  localparam int LW = $clog2(TRACE_LEN + 1);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [LEN_W-1:0] TL_CFG = LEN_W'(TRACE_LEN);

  logic [2*DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [LW-1:0] len_eff, len_l, beat, in_cnt;
  logic          busy, full, accept, push, pop, start;

  always_comb begin
    if (cfg_len == '0)         len_eff = LW'(1);
    else if (cfg_len > TL_CFG) len_eff = LW'(TRACE_LEN);
    else                       len_eff = cfg_len[LW-1:0];
  end

  assign full      = (count == CW'(DEPTH));
  assign accept    = wr_valid && (wr_sop || (in_cnt != '0 && in_cnt < len_eff));
  assign push      = accept && !full;
  assign pop       = busy && (beat < len_l);
  assign pri_ready = !busy && !out_valid && (count >= CW'(len_eff));
  assign start     = rd_req && pri_ready;

  always_ff @(posedge clk)
    if (push) mem[wptr] <= {wr_i, wr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      in_cnt   <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) begin
        in_cnt <= wr_sop ? LW'(1) : in_cnt + 1'b1;
        if (full) overflow <= 1'b1;
      end
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      beat      <= '0;
      len_l     <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (busy) begin
      out_valid <= 1'b1;
      out_last  <= (beat == LW'(TRACE_LEN - 1));
      {out_i, out_q} <= pop ? mem[rptr] : '0;
      beat <= beat + 1'b1;
      if (beat == LW'(TRACE_LEN - 1)) busy <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      if (start) begin
        busy  <= 1'b1;
        beat  <= '0;
        len_l <= len_eff;
      end
    end
  end
endmodule

// File: rtl/pri_pad_buffer_chk.sv
module pri_pad_buffer_chk #(
  parameter int DATA_W    = 16,
  parameter int TRACE_LEN = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pri_ready,
  input logic              rd_req,
  input logic              out_valid,
  input logic              out_last,
  input logic [DATA_W-1:0] out_i,
  input logic [DATA_W-1:0] out_q,
  input logic              overflow
);
  logic [31:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else        run <= out_valid ? run + 1 : '0;

  AST_START_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && pri_ready |=> !pri_ready ##1 out_valid); // R5
  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (run == 32'(TRACE_LEN - 1)))); // R7
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R7
  AST_TRACE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_i == '0 && out_q == '0)); // R6
  AST_NO_READY_IN_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !pri_ready); // R8
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R10
endmodule

bind pri_pad_buffer pri_pad_buffer_chk #(.DATA_W(DATA_W), .TRACE_LEN(TRACE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pri_ready(pri_ready), .rd_req(rd_req),
  .out_valid(out_valid), .out_last(out_last), .out_i(out_i), .out_q(out_q),
  .overflow(overflow)
);

// File: tb/sim_pri_pad_buffer.sv
module sim_pri_pad_buffer;
  localparam int CLK_T = 10;
  localparam int DW = 16;
  localparam int TL = 1024;
  localparam int DEPTH = 1024;
  localparam int LEN_W = 16;

  logic clk = 0, rst_n = 0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic wr_valid = 0, wr_sop = 0, rd_req = 0;
  logic [DW-1:0] wr_i = '0, wr_q = '0;
  logic pri_ready, out_valid, out_last, overflow;
  logic [DW-1:0] out_i, out_q;

  pri_pad_buffer #(.DATA_W(DW), .TRACE_LEN(TL), .DEPTH(DEPTH), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .wr_valid(wr_valid), .wr_sop(wr_sop),
    .wr_i(wr_i), .wr_q(wr_q), .pri_ready(pri_ready), .rd_req(rd_req),
    .out_valid(out_valid), .out_last(out_last), .out_i(out_i), .out_q(out_q),
    .overflow(overflow));

  always #(CLK_T/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic int eff(input int c);
    if (c == 0) return 1;
    if (c > TL) return TL;
    return c;
  endfunction

  logic [2*DW-1:0] mq[$];
  int  m_in, m_beat, m_len;
  bit  m_act, m_ov, m_ol, m_ovf;
  logic [2*DW-1:0] m_od;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_in = 0; m_beat = 0; m_len = 0;
      m_act = 0; m_ov = 0; m_ol = 0; m_ovf = 0; m_od = '0;
    end else begin
      int le; bit full, rdy, st, acc;
      le   = eff(int'(cfg_len));
      full = (mq.size() == DEPTH);
      rdy  = !m_act && !m_ov && (mq.size() >= le);
      st   = rd_req && rdy;
      if (m_act) begin
        m_ov = 1;
        m_od = (m_beat < m_len) ? mq.pop_front() : '0;
        m_ol = (m_beat == TL - 1);
        if (m_ol) m_act = 0;
        m_beat++;
      end else begin
        m_ov = 0; m_ol = 0; m_od = '0;
        if (st) begin m_act = 1; m_beat = 0; m_len = le; end
      end
      acc = wr_valid && (wr_sop || (m_in != 0 && m_in < le));
      if (acc) begin
        m_in = wr_sop ? 1 : m_in + 1;
        if (full) m_ovf = 1;
        else mq.push_back({wr_i, wr_q});
      end
    end
    #(CLK_T/4);
    if (rst_n && !done) begin
      bit erdy;
      erdy = !m_act && !m_ov && (mq.size() >= eff(int'(cfg_len)));
      chk(pri_ready == erdy, "R4 pri_ready", pri_ready, erdy);
      chk(out_valid == m_ov, "R5 out_valid", out_valid, m_ov);
      chk(out_i == m_od[2*DW-1:DW], "R6 out_i", out_i, m_od[2*DW-1:DW]);
      chk(out_q == m_od[DW-1:0], "R6 out_q", out_q, m_od[DW-1:0]);
      chk(out_last == m_ol, "R7 out_last", out_last, m_ol);
      chk(overflow == m_ovf, "R10 overflow", overflow, m_ovf);
    end
  end

  task automatic put(input bit sop);
    @(negedge clk);
    wr_valid = 1; wr_sop = sop; wr_i = DW'($urandom); wr_q = DW'($urandom);
  endtask

  task automatic quiet();
    @(negedge clk);
    wr_valid = 0; wr_sop = 0;
  endtask

  task automatic send_pri(input int n, input int extra);
    put(1);
    for (int k = 1; k < n + extra; k++) put(0);
    quiet();
  endtask

  task automatic pulse_req();
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
  endtask

  task automatic wait_trace();
    do @(negedge clk); while (!out_last);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset values
    chk(pri_ready == 0, "R1 pri_ready", pri_ready, 0);
    chk(out_valid == 0 && out_last == 0, "R1 valid/last", {out_valid, out_last}, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);
    chk(out_i == 0 && out_q == 0, "R1 data", {out_i, out_q}, 0);
    rst_n = 1;

    cfg_len = 100;
    // R2: writes before any start marker are discarded
    put(0); put(0); put(0); quiet();
    // R9: request with ready low is ignored
    pulse_req();
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R9 ignored request", out_valid, 0);
    put(1);
    for (int k = 1; k < 99; k++) put(0);
    quiet();
    chk(pri_ready == 0, "R2 partial interval", pri_ready, 0);
    put(0); put(0); put(0); put(0); put(0); put(0); quiet();
    chk(pri_ready == 1, "R2 complete interval", pri_ready, 1);
    pulse_req();
    wait_trace();
    chk(pri_ready == 0, "R2 extras discarded", pri_ready, 0);

    // R3: zero length acts as one
    cfg_len = 0;
    put(1); quiet();
    chk(pri_ready == 1, "R3 zero length", pri_ready, 1);
    pulse_req();
    wait_trace();

    // R8: two intervals stored, request held high
    cfg_len = 300;
    send_pri(300, 0);
    send_pri(300, 0);
    @(negedge clk); rd_req = 1;
    repeat (500) @(negedge clk);
    chk(pri_ready == 0, "R8 ready held off in trace", pri_ready, 0);
    wait_trace();
    wait_trace();
    rd_req = 0;
    repeat (3) @(negedge clk);

    // R3 clamp and R10 overflow
    cfg_len = 5000;
    send_pri(TL, 0);
    chk(pri_ready == 1, "R3 clamp to trace length", pri_ready, 1);
    send_pri(4, 0);
    chk(overflow == 1, "R10 overflow set", overflow, 1);
    pulse_req();
    wait_trace();
    chk(overflow == 1, "R10 overflow sticky", overflow, 1);
    chk(pri_ready == 0, "R10 dropped samples not stored", pri_ready, 0);

    repeat (5) @(negedge clk);
    done = 1;
    report();
  end
endmodule